// File: doc/BRIEF.md
# Strike-Directed Configuration Memory Scrubber

This block keeps the configuration memory of a tiled reconfigurable fabric clean. It treats the memory as one region per tile, each region a fixed number of words, and visits the regions one after another. Every region is visited, including tiles that hold no active logic and spare tiles, so upsets that no voter could observe are still found. Each visit compares against, or copies from, a golden store that holds the known-good contents.

Two scrub styles are offered. The overwrite style copies every word of the region from the golden store without looking at the current contents. The compare style reads the region and checks every word against the golden store. It rewrites the whole region only when at least one word differs, and then reports the repair and counts it per region. A strike sensor reports particle hits as X/Y coordinates. With strike steering on, each hit is mapped to the tile under it and marked pending. At the next region boundary, pending tiles are scrubbed ahead of the ascending walk, and the walk then continues from where it stopped.

Top module: `cfg_scrubber`

## Requirements
- R1: After reset no memory read or write is issued, neither pulse output is high, and every per-region fault count is zero.
- R2: In compare style a visit reads every word of the region from both memories at the same address, and a region whose words all match receives no write.
- R3: In compare style a difference in any word makes the block rewrite all words of that region, each word taken from the golden store at the same address, so the region equals the golden copy afterwards. The address is {region, word}.
- R4: After a corrective rewrite in compare style, repaired_valid is high for exactly one cycle with the region index, and that region's fault count (CNT_W bits, region r at bits r*CNT_W upward) rises by one and saturates at its maximum.
- R5: In overwrite style every word of every visited region is written from the golden store, no repaired pulse is raised, and the fault counts do not change.
- R6: With no pending tiles, regions are visited in ascending order 0, 1, ... NREG-1 and then 0 again.
- R7: With strike steering on, a tile marked by a strike is visited at the next region boundary before the ascending walk. After the priority work the walk resumes at the region it would have visited next.
- R8: When several tiles are pending, the lowest tile index is served first. Repeated strikes on a tile that is already pending give one visit.
- R9: A strike at (x, y) marks tile (y*TILES_Y/2^COORD_W)*TILES_X + x*TILES_X/2^COORD_W. With the defaults this is (y/4)*4 + x/4.
- R10: With strike steering off, strike reports are dropped and are not kept for later.
- R11: When enable is low the block finishes the current region and then issues no memory access and no pulse until enable rises.
- R12: done_valid is high for one cycle at the end of every visit, with the region index. A repaired pulse coincides with the done pulse of the same region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run scrubbing; sampled at region boundaries |
| mode_readback | input | 1 | 1 selects compare style, 0 selects overwrite style |
| mode_env | input | 1 | Strike steering on |
| strike_valid | input | 1 | Strike report present this cycle |
| strike_x | input | COORD_W | Strike X coordinate |
| strike_y | input | COORD_W | Strike Y coordinate |
| cfg_addr | output | AW | Configuration memory word address {region, word} |
| cfg_rd_en | output | 1 | Configuration read; data returned next cycle |
| cfg_rd_data | input | DATA_W | Configuration read data |
| cfg_wr_en | output | 1 | Configuration write |
| cfg_wr_data | output | DATA_W | Configuration write data |
| gold_addr | output | AW | Golden store word address |
| gold_rd_en | output | 1 | Golden read; data returned next cycle |
| gold_rd_data | input | DATA_W | Golden read data |
| done_valid | output | 1 | One-cycle pulse at the end of a visit |
| done_region | output | RW | Region just visited |
| repaired_valid | output | 1 | One-cycle pulse after a corrective rewrite |
| repaired_region | output | RW | Region just repaired |
| fault_counts | output | NREG*CNT_W | Saturating per-region repair counts |

## Verification
The bench places single-word faults in the first word of the first region and the last word of the last region. A block that dropped the final comparison of a region would miss the second fault, and one that wrote only the bad word would show the wrong write count. It sends a duplicate strike and strikes out of index order. A design without merging would visit a tile twice, and one with the wrong priority would show a different visit order. A strike arriving in the middle of a region checks that the block pre-empts only at the boundary and then resumes the ascending walk rather than restarting it. Further cases cover strikes sent while steering is off, which must leave no trace, and repeated repairs of one region, which must saturate that region's counter rather than wrap it.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_READ   = 3'd1,
      ST_RDRAIN = 3'd2,
      ST_WRITE  = 3'd3,
      ST_WDRAIN = 3'd4,
      ST_DONE   = 3'd5
   } scrub_state_t;

endpackage

// File: rtl/scrub_strike_map.sv
module scrub_strike_map #(
   parameter int COORD_W = 4,
   parameter int TILES_X = 4,
   parameter int TILES_Y = 4,
   parameter int RW      = 4
) (
   input  logic [COORD_W-1:0] x,
   input  logic [COORD_W-1:0] y,
   output logic [RW-1:0]      tile
);
   localparam int NCOORD = 1 << COORD_W;

   logic [RW-1:0] col_lut [NCOORD];
   logic [RW-1:0] row_lut [NCOORD];

   // Column and row contribution tables, one entry per coordinate value
   for (genvar i = 0; i < NCOORD; i++) begin : g_lut
      assign col_lut[i] = RW'((i * TILES_X) / NCOORD);
      assign row_lut[i] = RW'(((i * TILES_Y) / NCOORD) * TILES_X);
   end

   assign tile = col_lut[x] + row_lut[y];

endmodule

// File: rtl/scrub_pending.sv
module scrub_pending #(
   parameter int NREG = 16,
   parameter int RW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_valid,
   input  logic [RW-1:0] set_idx,
   input  logic          take,
   output logic          any,
   output logic [RW-1:0] pick_idx
);
   logic [NREG-1:0] pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= '0;
      end else begin
         if (take)      pend[pick_idx] <= 1'b0;
         if (set_valid) pend[set_idx]  <= 1'b1;   // a fresh strike wins
      end
   end

   // Lowest pending index has priority
   always_comb begin
      pick_idx = '0;
      for (int i = NREG - 1; i >= 0; i--) begin
         if (pend[i]) pick_idx = RW'(i);
      end
   end

   assign any = |pend;

endmodule

// File: rtl/scrub_fault_ctrs.sv
module scrub_fault_ctrs #(
   parameter int NREG  = 16,
   parameter int RW    = 4,
   parameter int CNT_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  inc_valid,
   input  logic [RW-1:0]         inc_idx,
   output logic [NREG*CNT_W-1:0] counts
);
   for (genvar g = 0; g < NREG; g++) begin : g_ctr
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (inc_valid && inc_idx == RW'(g) && cnt != {CNT_W{1'b1}}) begin
            cnt <= cnt + CNT_W'(1);
         end
      end
      assign counts[g*CNT_W +: CNT_W] = cnt;
   end

endmodule

// File: rtl/scrub_engine.sv
module scrub_engine
   import scrub_pkg::*;
#(
   parameter int NREG   = 16,
   parameter int WORDS  = 8,
   parameter int DATA_W = 16,
   parameter int RW     = 4,
   parameter int WW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              mode_readback,
   input  logic              mode_env,
   input  logic              prio_any,
   input  logic [RW-1:0]     prio_idx,
   output logic              prio_take,
   output logic [RW+WW-1:0]  cfg_addr,
   output logic              cfg_rd_en,
   input  logic [DATA_W-1:0] cfg_rd_data,
   output logic              cfg_wr_en,
   output logic [DATA_W-1:0] cfg_wr_data,
   output logic [RW+WW-1:0]  gold_addr,
   output logic              gold_rd_en,
   input  logic [DATA_W-1:0] gold_rd_data,
   output logic              done_valid,
   output logic [RW-1:0]     done_region,
   output logic              repaired_valid,
   output logic [RW-1:0]     repaired_region
);
   localparam logic [WW-1:0] LAST_WORD = WW'(WORDS - 1);
   localparam logic [RW-1:0] LAST_REG  = RW'(NREG - 1);

   scrub_state_t  state;
   logic [RW-1:0] region;
   logic [RW-1:0] seq_ptr;
   logic [WW-1:0] word;
   logic [WW-1:0] wr_word;
   logic          cmp_v;
   logic          wr_v;
   logic          mismatch;
   logic          from_prio;
   logic          rb;

   logic          use_prio;
   logic          differ;
   logic          mismatch_nxt;
   logic          last;

   assign use_prio     = mode_env && prio_any;
   assign differ       = cmp_v && (cfg_rd_data != gold_rd_data);
   assign mismatch_nxt = mismatch || differ;
   assign last         = (word == LAST_WORD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         region    <= '0;
         seq_ptr   <= '0;
         word      <= '0;
         wr_word   <= '0;
         cmp_v     <= 1'b0;
         wr_v      <= 1'b0;
         mismatch  <= 1'b0;
         from_prio <= 1'b0;
         rb        <= 1'b0;
      end else begin
         cmp_v   <= (state == ST_READ);
         wr_v    <= (state == ST_WRITE);
         wr_word <= word;
         if (differ) mismatch <= 1'b1;
         case (state)
            ST_IDLE: begin
               if (enable) begin
                  region    <= use_prio ? prio_idx : seq_ptr;
                  from_prio <= use_prio;
                  rb        <= mode_readback;
                  word      <= '0;
                  mismatch  <= 1'b0;
                  state     <= mode_readback ? ST_READ : ST_WRITE;
               end
            end
            ST_READ: begin
               word <= word + WW'(1);
               if (last) begin
                  word  <= '0;
                  state <= ST_RDRAIN;
               end
            end
            ST_RDRAIN: begin
               state <= mismatch_nxt ? ST_WRITE : ST_DONE;
            end
            ST_WRITE: begin
               word <= word + WW'(1);
               if (last) begin
                  word  <= '0;
                  state <= ST_WDRAIN;
               end
            end
            ST_WDRAIN: begin
               state <= ST_DONE;
            end
            ST_DONE: begin
               if (!from_prio) begin
                  seq_ptr <= (seq_ptr == LAST_REG) ? '0 : seq_ptr + RW'(1);
               end
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign prio_take       = (state == ST_IDLE) && enable && use_prio;
   assign cfg_rd_en       = (state == ST_READ);
   assign gold_rd_en      = (state == ST_READ) || (state == ST_WRITE);
   assign gold_addr       = {region, word};
   assign cfg_addr        = wr_v ? {region, wr_word} : {region, word};
   assign cfg_wr_en       = wr_v;
   assign cfg_wr_data     = gold_rd_data;
   assign done_valid      = (state == ST_DONE);
   assign done_region     = region;
   assign repaired_valid  = (state == ST_DONE) && rb && mismatch;
   assign repaired_region = region;

endmodule

// File: rtl/cfg_scrubber.sv
module cfg_scrubber #(
   parameter int TILES_X = 4,
   parameter int TILES_Y = 4,
   parameter int WORDS   = 8,
   parameter int DATA_W  = 16,
   parameter int COORD_W = 4,
   parameter int CNT_W   = 4,
   localparam int NREG   = TILES_X * TILES_Y,
   localparam int RW     = (NREG > 1) ? $clog2(NREG) : 1,
   localparam int WW     = (WORDS > 1) ? $clog2(WORDS) : 1,
   localparam int AW     = RW + WW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  enable,
   input  logic                  mode_readback,
   input  logic                  mode_env,
   input  logic                  strike_valid,
   input  logic [COORD_W-1:0]    strike_x,
   input  logic [COORD_W-1:0]    strike_y,
   output logic [AW-1:0]         cfg_addr,
   output logic                  cfg_rd_en,
   input  logic [DATA_W-1:0]     cfg_rd_data,
   output logic                  cfg_wr_en,
   output logic [DATA_W-1:0]     cfg_wr_data,
   output logic [AW-1:0]         gold_addr,
   output logic                  gold_rd_en,
   input  logic [DATA_W-1:0]     gold_rd_data,
   output logic                  done_valid,
   output logic [RW-1:0]         done_region,
   output logic                  repaired_valid,
   output logic [RW-1:0]         repaired_region,
   output logic [NREG*CNT_W-1:0] fault_counts
);
   // Elaboration-time parameter checks
   if (NREG < 2) begin : g_bad_nreg
      $error("cfg_scrubber: at least two tiles are needed");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("cfg_scrubber: WORDS must be a power of two, at least 2");
   end
   if (TILES_X > (1 << COORD_W) || TILES_Y > (1 << COORD_W)) begin : g_bad_grid
      $error("cfg_scrubber: tile grid finer than sensor grid");
   end
   if (CNT_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("cfg_scrubber: widths must be positive");
   end

   logic [RW-1:0] strike_tile;
   logic          prio_any;
   logic [RW-1:0] prio_idx;
   logic          prio_take;

   scrub_strike_map #(
      .COORD_W (COORD_W),
      .TILES_X (TILES_X),
      .TILES_Y (TILES_Y),
      .RW      (RW)
   ) map_i (
      .x    (strike_x),
      .y    (strike_y),
      .tile (strike_tile)
   );

   scrub_pending #(
      .NREG (NREG),
      .RW   (RW)
   ) pend_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_valid (strike_valid && mode_env),
      .set_idx   (strike_tile),
      .take      (prio_take),
      .any       (prio_any),
      .pick_idx  (prio_idx)
   );

   scrub_engine #(
      .NREG   (NREG),
      .WORDS  (WORDS),
      .DATA_W (DATA_W),
      .RW     (RW),
      .WW     (WW)
   ) eng_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .enable          (enable),
      .mode_readback   (mode_readback),
      .mode_env        (mode_env),
      .prio_any        (prio_any),
      .prio_idx        (prio_idx),
      .prio_take       (prio_take),
      .cfg_addr        (cfg_addr),
      .cfg_rd_en       (cfg_rd_en),
      .cfg_rd_data     (cfg_rd_data),
      .cfg_wr_en       (cfg_wr_en),
      .cfg_wr_data     (cfg_wr_data),
      .gold_addr       (gold_addr),
      .gold_rd_en      (gold_rd_en),
      .gold_rd_data    (gold_rd_data),
      .done_valid      (done_valid),
      .done_region     (done_region),
      .repaired_valid  (repaired_valid),
      .repaired_region (repaired_region)
   );

   scrub_fault_ctrs #(
      .NREG  (NREG),
      .RW    (RW),
      .CNT_W (CNT_W)
   ) ctr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_valid (repaired_valid),
      .inc_idx   (repaired_region),
      .counts    (fault_counts)
   );

endmodule

// File: rtl/cfg_scrubber_chk.sv
module cfg_scrubber_chk #(
   parameter int RW = 4,
   parameter int AW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] cfg_addr,
   input logic          cfg_rd_en,
   input logic          cfg_wr_en,
   input logic [AW-1:0] gold_addr,
   input logic          gold_rd_en,
   input logic          done_valid,
   input logic [RW-1:0] done_region,
   input logic          repaired_valid,
   input logic [RW-1:0] repaired_region
);
   assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cfg_rd_en, cfg_wr_en}));

   assert_rd_paired_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd_en |-> (gold_rd_en && gold_addr == cfg_addr));

   assert_wr_from_gold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_en |-> ($past(gold_rd_en) && cfg_addr == $past(gold_addr)));

   assert_repair_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      repaired_valid |=> !repaired_valid);

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   assert_repair_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
      repaired_valid |-> (done_valid && done_region == repaired_region));

endmodule

bind cfg_scrubber cfg_scrubber_chk #(
   .RW (RW),
   .AW (AW)
) chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .cfg_addr        (cfg_addr),
   .cfg_rd_en       (cfg_rd_en),
   .cfg_wr_en       (cfg_wr_en),
   .gold_addr       (gold_addr),
   .gold_rd_en      (gold_rd_en),
   .done_valid      (done_valid),
   .done_region     (done_region),
   .repaired_valid  (repaired_valid),
   .repaired_region (repaired_region)
);

// File: tb/cfg_scrubber_tb_top.sv
module cfg_scrubber_tb_top;
   localparam int NREG   = 16;
   localparam int WORDS  = 8;
   localparam int DATA_W = 16;
   localparam int CNT_W  = 4;
   localparam int RW     = 4;
   localparam int AW     = 7;
   localparam int MEMSZ  = NREG * WORDS;
   localparam int WDOG   = 150000;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic                  rst_n = 1'b0;
   logic                  enable = 1'b0;
   logic                  mode_readback = 1'b1;
   logic                  mode_env = 1'b0;
   logic                  strike_valid = 1'b0;
   logic [3:0]            strike_x = '0;
   logic [3:0]            strike_y = '0;
   logic [AW-1:0]         cfg_addr;
   logic                  cfg_rd_en;
   logic [DATA_W-1:0]     cfg_rd_data = '0;
   logic                  cfg_wr_en;
   logic [DATA_W-1:0]     cfg_wr_data;
   logic [AW-1:0]         gold_addr;
   logic                  gold_rd_en;
   logic [DATA_W-1:0]     gold_rd_data = '0;
   logic                  done_valid;
   logic [RW-1:0]         done_region;
   logic                  repaired_valid;
   logic [RW-1:0]         repaired_region;
   logic [NREG*CNT_W-1:0] fault_counts;

   cfg_scrubber dut_i (
      .clk, .rst_n, .enable, .mode_readback, .mode_env,
      .strike_valid, .strike_x, .strike_y,
      .cfg_addr, .cfg_rd_en, .cfg_rd_data, .cfg_wr_en, .cfg_wr_data,
      .gold_addr, .gold_rd_en, .gold_rd_data,
      .done_valid, .done_region, .repaired_valid, .repaired_region,
      .fault_counts
   );

   // Memory models: one-cycle read latency
   logic [DATA_W-1:0] cmem [MEMSZ];
   logic [DATA_W-1:0] gmem [MEMSZ];
   logic              cor_en = 1'b0;
   logic [AW-1:0]     cor_addr = '0;
   logic [DATA_W-1:0] cor_data = '0;

   always @(posedge clk) begin
      if (cfg_wr_en)  cmem[cfg_addr] <= cfg_wr_data;
      if (cor_en)     cmem[cor_addr] <= cor_data;
      if (cfg_rd_en)  cfg_rd_data    <= cmem[cfg_addr];
      if (gold_rd_en) gold_rd_data   <= gmem[gold_addr];
   end

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_fail = 0;
   bit timed_out = 0;
   int visits[$];
   int reps[$];
   int wr_cnt [NREG];
   int rep_cnt [NREG];
   bit dirty [NREG];
   int exp_fc [NREG];

   task automatic check(input string req, input int act, input int exp, input string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int map_tile(input int x, input int y);
      return (y / 4) * 4 + x / 4;
   endfunction

   function automatic int fc(input int r);
      return int'(fault_counts[r*CNT_W +: CNT_W]);
   endfunction

   task automatic clear_stats();
      visits.delete();
      reps.delete();
      for (int r = 0; r < NREG; r++) begin
         wr_cnt[r] = 0;
         rep_cnt[r] = 0;
      end
   endtask

   // Run n visits, stop at the boundary, then confirm the block stays quiet (R11)
   task automatic run_visits(input int n);
      int got = 0;
      bit quiet = 1;
      enable = 1'b1;
      while (got < n && !timed_out) begin
         @(negedge clk);
         if (cyc > WDOG) begin
            timed_out = 1;
            check("watchdog", 0, 1, "run did not complete");
         end
         if (cfg_wr_en) wr_cnt[int'(cfg_addr) / WORDS]++;
         if (repaired_valid) begin
            reps.push_back(int'(repaired_region));
            rep_cnt[repaired_region]++;
         end
         if (done_valid) begin
            visits.push_back(int'(done_region));
            got++;
         end
      end
      enable = 1'b0;
      repeat (2 * WORDS + 6) begin
         @(negedge clk);
         if (done_valid || cfg_rd_en || cfg_wr_en) quiet = 0;
      end
      check("R11", int'(quiet), 1, "activity while enable low");
   endtask

   task automatic corrupt(input int r, input int w);
      int a = r * WORDS + w;
      @(negedge clk);
      cor_en = 1'b1;
      cor_addr = AW'(a);
      cor_data = gmem[a] ^ DATA_W'(($urandom % 16'hFFFF) + 1);
      @(negedge clk);
      cor_en = 1'b0;
      dirty[r] = 1;
   endtask

   task automatic strike(input int x, input int y);
      @(negedge clk);
      strike_valid = 1'b1;
      strike_x = 4'(x);
      strike_y = 4'(y);
      @(negedge clk);
      strike_valid = 1'b0;
   endtask

   task automatic check_clean(input string req);
      int bad = 0;
      @(negedge clk);
      for (int a = 0; a < MEMSZ; a++) if (cmem[a] != gmem[a]) bad++;
      check(req, bad, 0, "words differing from golden");
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int r = 0; r < NREG; r++) exp_fc[r] = 0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int a = 0; a < MEMSZ; a++) begin
         gmem[a] = DATA_W'($urandom);
         cmem[a] = gmem[a];
      end
      for (int r = 0; r < NREG; r++) begin
         dirty[r] = 0;
         exp_fc[r] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1", int'(cfg_rd_en), 0, "cfg_rd_en after reset");
      check("R1", int'(cfg_wr_en), 0, "cfg_wr_en after reset");
      check("R1", int'(done_valid || repaired_valid), 0, "pulses after reset");
      check("R1", int'(fault_counts == '0), 1, "fault counts zero");

      // R6, R2: clean memory, compare style, two full passes with wrap
      clear_stats();
      run_visits(2 * NREG);
      for (int i = 0; i < 2 * NREG; i++) check("R6", visits[i], i % NREG, $sformatf("visit %0d", i));
      begin
         int tw = 0;
         for (int r = 0; r < NREG; r++) tw += wr_cnt[r];
         check("R2", tw, 0, "writes on clean memory");
      end
      check("R4", reps.size(), 0, "repairs on clean memory");

      // R3, R4: random faults plus first-word and last-word corners
      clear_stats();
      for (int r = 0; r < NREG; r++) dirty[r] = 0;
      corrupt(0, 0);
      corrupt(NREG - 1, WORDS - 1);
      for (int r = 1; r < NREG - 1; r++) if ($urandom % 3 == 0) corrupt(r, int'($urandom % WORDS));
      run_visits(NREG);
      for (int r = 0; r < NREG; r++) begin
         if (dirty[r]) exp_fc[r]++;
         check("R3", wr_cnt[r], dirty[r] ? WORDS : 0, $sformatf("writes region %0d", r));
         check("R4", rep_cnt[r], dirty[r] ? 1 : 0, $sformatf("repair pulses region %0d", r));
         check("R4", fc(r), exp_fc[r], $sformatf("fault count region %0d", r));
      end
      check_clean("R3");

      // R4: saturation of a region's counter
      for (int k = 0; k < 16; k++) begin
         corrupt(5, k % WORDS);
         clear_stats();
         run_visits(NREG);
         if (exp_fc[5] < 15) exp_fc[5]++;
      end
      check("R4", fc(5), 15, "saturated fault count");

      // R5: overwrite style
      mode_readback = 1'b0;
      for (int r = 0; r < NREG; r++) dirty[r] = 0;
      corrupt(2, 3);
      corrupt(9, 7);
      clear_stats();
      run_visits(NREG);
      for (int r = 0; r < NREG; r++) check("R5", wr_cnt[r], WORDS, $sformatf("blind writes region %0d", r));
      check("R5", reps.size(), 0, "repair pulses in overwrite style");
      check("R5", fc(5), 15, "counts unchanged in overwrite style");
      check("R5", fc(2), exp_fc[2], "count region 2 unchanged");
      check_clean("R5");

      // R7, R8: strike steering with duplicates and out-of-order tiles
      mode_readback = 1'b1;
      do_reset();
      mode_env = 1'b1;
      strike(5, 9);    // tile 9
      strike(13, 2);   // tile 3
      strike(6, 10);   // tile 9 again
      clear_stats();
      run_visits(4);
      check("R8", visits[0], 3, "lowest pending first");
      check("R8", visits[1], 9, "duplicate merged, single visit");
      check("R7", visits[2], 0, "walk starts after priority work");
      check("R7", visits[3], 1, "walk continues");

      // R7: strike mid-region pre-empts only at the boundary
      enable = 1'b1;
      repeat (3) @(negedge clk);
      strike(0, 12);   // tile 12
      clear_stats();
      run_visits(3);
      check("R7", visits[0], 2, "current region completes");
      check("R7", visits[1], 12, "priority tile at boundary");
      check("R7", visits[2], 3, "walk resumes at saved position");

      // R10: strikes dropped while steering is off
      mode_env = 1'b0;
      strike(15, 15);
      clear_stats();
      run_visits(1);
      check("R10", visits[0], 4, "strike ignored while off");
      mode_env = 1'b1;
      clear_stats();
      run_visits(1);
      check("R10", visits[0], 5, "ignored strike not retained");

      // R9: coordinate to tile mapping, random positions
      for (int k = 0; k < 10; k++) begin
         int x = int'($urandom % 16);
         int y = int'($urandom % 16);
         strike(x, y);
         clear_stats();
         run_visits(1);
         check("R9", visits[0], map_tile(x, y), $sformatf("strike at %0d,%0d", x, y));
      end
      clear_stats();
      run_visits(1);
      check("R7", visits[0], 6, "walk resumes after many priority visits");
      check("R12", int'(done_valid), 0, "done pulse ended");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule